// File: doc/BRIEF.md
# Base Timer with Match Reset

This block is a 16-bit base counter for a timer subsystem. A small register interface selects where count steps come from: no source at all, an internal clock-enable strobe, or a pair of quadrature phase inputs. A run bit clamps the counter to zero for as long as it is clear. Software can load a start value and read the count back. The value read back is one ahead of the counter.

A compare register can wrap the counter to zero when the count reaches it, which turns the free-running counter into a period counter. An overflow pulse fires when the counter carries out of bit 15, or out of bit 14 if software selects that bit. The pulse can drive an interrupt line. A direction field chooses up or down counting for the strobe source. The same field must also select quadrature mode before the phase inputs are allowed to count.

Top module: `base_timer`

## Requirements
- R1: After reset every control field and the compare value are zero, the counter is zero, `ovf_irq` is low, and every register reads 0.
- R2: Register map. Address 0 is the count. Address 1 is control A: bits 1:0 are the source, bit 2 is match enable, bit 7 is overflow select, and bits 6:3 always read 0, whatever is written to them. Address 2 is control B: bit 0 is run and bits 2:1 are direction. Address 3 is the compare value.
- R3: Source 00 (stopped) and source 01 (reserved) leave the count unchanged. With source 11, the count takes one step on each clock in which `cnt_tick` is high.
- R4: While run is 0, the counter is forced to zero on every clock, whatever the source.
- R5: While run is 1, a read of address 0 returns the count plus one, modulo 2^16. While run is 0, it returns 0.
- R6: While run is 1, a write to address 0 loads the written value, and counting continues from that value. A load wins over a step in the same clock.
- R7: While run is 0, writes to address 0 have no effect.
- R8: With the strobe source, direction 00 counts up and direction 01 counts down.
- R9: With match enable set, a step taken while the count equals the compare value sets the count to 0 and does not advance it.
- R10: `ovf_irq` is high for exactly one cycle, the cycle after an up step carries out of the selected bit. Overflow select 0 selects bit 15, so the pulse follows 0xFFFF to 0x0000. Overflow select 1 selects bit 14, so the pulse follows any count whose low 15 bits are all ones. Down steps and match resets never pulse.
- R11: With source 10 and direction 10, the phase pair {A,B} passes through a two-flop synchronizer. The order 00, 01, 11, 10, 00 steps the count up by one per transition, and the reverse order steps it down. A transition that changes both phases is ignored.
- R12: Source 10 with any direction other than 10 does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for bus_addr (combinational) |
| cnt_tick | input | 1 | Internal count enable strobe |
| quad_a | input | 1 | Quadrature phase A (asynchronous) |
| quad_b | input | 1 | Quadrature phase B (asynchronous) |
| ovf_irq | output | 1 | One-cycle overflow pulse |

## Verification
Runs of strobes are applied under every source code and both directions. This tells a counting source apart from a stopped one, and up counting from down counting. Loads are placed near 0x7FFF and 0xFFFF so that each overflow select is shown to fire on its own carry and stay quiet on the other one. Quadrature input is driven forward, backward and with a two-phase jump, which separates a true step from a glitch. A strobe arriving with a load, and a step at the compare value, show which action wins in each case.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [1:0] {
    SRC_STOP = 2'b00,
    SRC_RSVD = 2'b01,
    SRC_QUAD = 2'b10,
    SRC_TICK = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    DIR_UP   = 2'b00,
    DIR_DOWN = 2'b01,
    DIR_QUAD = 2'b10,
    DIR_RSVD = 2'b11
  } dir_e;

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_CTLA = 2'd1;
  localparam logic [1:0] ADDR_CTLB = 2'd2;
  localparam logic [1:0] ADDR_CMP  = 2'd3;

  localparam int CTLA_MATCH_BIT = 2;
  localparam int CTLA_OVF_BIT   = 7;
  localparam int CTLB_RUN_BIT   = 0;

endpackage

// File: rtl/bt_quad_dec.sv
module bt_quad_dec #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_a,
  input  logic phase_b,
  output logic step_up,
  output logic step_dn
);

  logic [SYNC_STAGES-1:0] sync_a_q, sync_b_q;
  logic [1:0] cur, prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_a_q <= '0;
          sync_b_q <= '0;
        end else begin
          sync_a_q <= phase_a;
          sync_b_q <= phase_b;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_a_q <= '0;
          sync_b_q <= '0;
        end else begin
          sync_a_q <= {sync_a_q[SYNC_STAGES-2:0], phase_a};
          sync_b_q <= {sync_b_q[SYNC_STAGES-2:0], phase_b};
        end
      end
    end
  endgenerate

  assign cur = {sync_a_q[SYNC_STAGES-1], sync_b_q[SYNC_STAGES-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= cur;
  end

  // Forward order 00 -> 01 -> 11 -> 10 -> 00; a one-bit change either way
  always_comb begin
    step_up = (cur[1] == prev_q[0]) && (cur[0] != prev_q[1]);
    step_dn = (cur[0] == prev_q[1]) && (cur[1] != prev_q[0]);
  end

  // R11: a jump of both phases never yields a step
  p_double_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur ^ prev_q) == 2'b11) |-> !(step_up || step_dn));

endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             step,
  input  logic             down,
  input  logic             match_en,
  input  logic [WIDTH-1:0] cmp_val,
  input  logic             ovf_sel,
  output logic [WIDTH-1:0] cnt,
  output logic             ovf_pulse
);

  localparam int HI_BIT = WIDTH - 1;
  localparam int LO_BIT = WIDTH - 2;

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             carry_hi, carry_lo, at_match;

  assign carry_hi = &cnt_q[HI_BIT:0];
  assign carry_lo = &cnt_q[LO_BIT:0];
  assign at_match = match_en && (cnt_q == cmp_val);

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = load_val;
    end else if (step) begin
      if (at_match) begin
        cnt_d = '0;
      end else if (down) begin
        cnt_d = cnt_q - WIDTH'(1);
      end else begin
        cnt_d = cnt_q + WIDTH'(1);
        ovf_d = ovf_sel ? carry_lo : carry_hi;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt       = cnt_q;
  assign ovf_pulse = ovf_q;

  p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && load) |=> (cnt_q == $past(load_val)));

  p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !step) |=> $stable(cnt_q));

  p_match_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && step && match_en && (cnt_q == cmp_val)) |=> (cnt_q == '0));

  p_ovf_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> !ovf_q);

  p_ovf_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q[LO_BIT:0] == '0));

endmodule

// File: rtl/base_timer.sv
module base_timer
  import bt_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic             cnt_tick,
  input  logic             quad_a,
  input  logic             quad_b,
  output logic             ovf_irq
);

  src_e             src_q, src_d;
  dir_e             dir_q, dir_d;
  logic             match_en_q, match_en_d;
  logic             ovf_sel_q, ovf_sel_d;
  logic             run_q, run_d;
  logic [WIDTH-1:0] cmp_q, cmp_d;

  logic             q_up, q_dn, quad_mode, step, down, load;
  logic [WIDTH-1:0] cnt;

  // Register next-state
  always_comb begin
    src_d      = src_q;
    dir_d      = dir_q;
    match_en_d = match_en_q;
    ovf_sel_d  = ovf_sel_q;
    run_d      = run_q;
    cmp_d      = cmp_q;
    if (bus_we) begin
      case (bus_addr)
        ADDR_CTLA: begin
          src_d      = src_e'(bus_wdata[1:0]);
          match_en_d = bus_wdata[CTLA_MATCH_BIT];
          ovf_sel_d  = bus_wdata[CTLA_OVF_BIT];
        end
        ADDR_CTLB: begin
          run_d = bus_wdata[CTLB_RUN_BIT];
          dir_d = dir_e'(bus_wdata[2:1]);
        end
        ADDR_CMP: cmp_d = bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q      <= SRC_STOP;
      dir_q      <= DIR_UP;
      match_en_q <= 1'b0;
      ovf_sel_q  <= 1'b0;
      run_q      <= 1'b0;
      cmp_q      <= '0;
    end else begin
      src_q      <= src_d;
      dir_q      <= dir_d;
      match_en_q <= match_en_d;
      ovf_sel_q  <= ovf_sel_d;
      run_q      <= run_d;
      cmp_q      <= cmp_d;
    end
  end

  bt_quad_dec #(.SYNC_STAGES(SYNC_STAGES)) i_quad (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_a (quad_a),
    .phase_b (quad_b),
    .step_up (q_up),
    .step_dn (q_dn)
  );

  // Count-source selection
  always_comb begin
    quad_mode = (src_q == SRC_QUAD) && (dir_q == DIR_QUAD);
    load      = bus_we && (bus_addr == ADDR_CNT);
    step      = 1'b0;
    down      = 1'b0;
    if (quad_mode) begin
      step = q_up || q_dn;
      down = q_dn;
    end else if (src_q == SRC_TICK) begin
      step = cnt_tick;
      down = (dir_q == DIR_DOWN);
    end
  end

  bt_counter #(.WIDTH(WIDTH)) i_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .load      (load),
    .load_val  (bus_wdata),
    .step      (step),
    .down      (down),
    .match_en  (match_en_q),
    .cmp_val   (cmp_q),
    .ovf_sel   (ovf_sel_q),
    .cnt       (cnt),
    .ovf_pulse (ovf_irq)
  );

  // Read mux
  always_comb begin
    case (bus_addr)
      ADDR_CNT:  bus_rdata = run_q ? (cnt + WIDTH'(1)) : '0;
      ADDR_CTLA: bus_rdata = {{(WIDTH-8){1'b0}}, ovf_sel_q, 4'b0000, match_en_q, src_q};
      ADDR_CTLB: bus_rdata = {{(WIDTH-3){1'b0}}, dir_q, run_q};
      default:   bus_rdata = cmp_q;
    endcase
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_CTLA) |-> (bus_rdata[6:3] == 4'b0000));

  p_stopped_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !load && (src_q == SRC_STOP || src_q == SRC_RSVD)) |=> $stable(cnt));

  p_quad_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !load && (src_q == SRC_QUAD) && (dir_q != DIR_QUAD)) |=> $stable(cnt));

endmodule

// File: tb/test_base_timer.sv
module test_base_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        cnt_tick = 1'b0;
  logic        quad_a = 1'b0;
  logic        quad_b = 1'b0;
  logic        ovf_irq;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;

  always #10 clk = ~clk;

  always @(posedge clk) if (ovf_irq) irq_seen++;

  base_timer i_base_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_tick(cnt_tick),
    .quad_a(quad_a), .quad_b(quad_b), .ovf_irq(ovf_irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    cnt_tick = 1'b1;
    repeat (n) @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic quad(input logic [1:0] ab);
    @(negedge clk);
    {quad_a, quad_b} = ab;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(2'd0, v); check("R1 count read", v, 16'h0000);
    rd(2'd1, v); check("R1 ctl A", v, 16'h0000);
    rd(2'd2, v); check("R1 ctl B", v, 16'h0000);
    rd(2'd3, v); check("R1 compare", v, 16'h0000);
    check("R1 irq", {15'b0, ovf_irq}, 16'h0000);
  endtask

  task automatic t_regmap;
    logic [15:0] v;
    wr(2'd1, 16'hFFFF); rd(2'd1, v); check("R2 ctl A reserved bits", v, 16'h0087);
    wr(2'd2, 16'hFFFF); rd(2'd2, v); check("R2 ctl B fields", v, 16'h0007);
    wr(2'd3, 16'hA5C3); rd(2'd3, v); check("R2 compare", v, 16'hA5C3);
    wr(2'd1, 16'h0000); wr(2'd2, 16'h0000); wr(2'd3, 16'h0000);
  endtask

  task automatic t_hold;
    logic [15:0] v;
    wr(2'd1, 16'h0003);           // tick source
    ticks(5);
    rd(2'd0, v); check("R4 held at zero", v, 16'h0000);
    wr(2'd0, 16'h1234);
    wr(2'd2, 16'h0001);           // run, so the count becomes visible
    rd(2'd0, v); check("R7 write while held ignored", v, 16'h0001);
  endtask

  task automatic t_load_count;
    logic [15:0] v;
    wr(2'd0, 16'h0100);
    rd(2'd0, v); check("R6 load, R5 read plus one", v, 16'h0101);
    ticks(5);
    rd(2'd0, v); check("R3 tick source counts", v, 16'h0106);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h0200; cnt_tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; cnt_tick = 1'b0;
    rd(2'd0, v); check("R6 load beats step", v, 16'h0201);
    wr(2'd2, 16'h0000);
    rd(2'd0, v); check("R5 held read", v, 16'h0000);
    wr(2'd2, 16'h0001);
  endtask

  task automatic t_stop_src;
    logic [15:0] v;
    wr(2'd0, 16'h0040);
    wr(2'd1, 16'h0000); ticks(4);
    rd(2'd0, v); check("R3 source 00 stopped", v, 16'h0041);
    wr(2'd1, 16'h0001); ticks(4);
    rd(2'd0, v); check("R3 source 01 stopped", v, 16'h0041);
    wr(2'd1, 16'h0003);
  endtask

  task automatic t_down;
    logic [15:0] v;
    irq_seen = 0;
    wr(2'd2, 16'h0003);           // run, direction down
    wr(2'd0, 16'h0010); ticks(3);
    rd(2'd0, v); check("R8 down count", v, 16'h000E);
    wr(2'd0, 16'h0001); ticks(2);
    rd(2'd0, v); check("R8 down through zero", v, 16'h0000);
    @(negedge clk);
    check("R10 no pulse on down wrap", irq_seen[15:0], 16'h0000);
    wr(2'd2, 16'h0001);
  endtask

  task automatic t_ovf(input logic sel, input logic [15:0] start, input logic exp_hit);
    logic [15:0] v;
    wr(2'd1, {8'h00, sel, 7'b0000011});
    wr(2'd0, start);
    @(negedge clk); cnt_tick = 1'b1;
    @(negedge clk);
    check(sel ? "R10 bit14 no early pulse" : "R10 bit15 no early pulse", {15'b0, ovf_irq}, 16'h0000);
    @(negedge clk); cnt_tick = 1'b0;
    check(sel ? "R10 bit14 pulse" : "R10 bit15 pulse", {15'b0, ovf_irq}, {15'b0, exp_hit});
    rd(2'd0, v); check("R10 count after carry", v, start + 16'h0003);
    @(negedge clk);
    check("R10 pulse one cycle", {15'b0, ovf_irq}, 16'h0000);
  endtask

  task automatic t_match;
    logic [15:0] v;
    irq_seen = 0;
    wr(2'd3, 16'h0005);
    wr(2'd1, 16'h0007);           // tick source, match enabled
    wr(2'd0, 16'h0003); ticks(2);
    rd(2'd0, v); check("R9 below compare", v, 16'h0006);
    ticks(1);
    rd(2'd0, v); check("R9 match reset", v, 16'h0001);
    ticks(2);
    rd(2'd0, v); check("R9 counts after match", v, 16'h0003);
    wr(2'd3, 16'hFFFF); wr(2'd0, 16'hFFFF); ticks(1);
    rd(2'd0, v); check("R9 match at top", v, 16'h0001);
    @(negedge clk);
    check("R10 no pulse on match reset", irq_seen[15:0], 16'h0000);
    wr(2'd1, 16'h0003);
  endtask

  task automatic t_quad;
    logic [15:0] v;
    wr(2'd1, 16'h0002);           // quadrature source
    wr(2'd2, 16'h0005);           // run, direction quadrature
    wr(2'd0, 16'h0100);
    quad(2'b01); quad(2'b11); quad(2'b10); quad(2'b00);
    rd(2'd0, v); check("R11 forward four", v, 16'h0105);
    quad(2'b10); quad(2'b11);
    rd(2'd0, v); check("R11 reverse two", v, 16'h0103);
    quad(2'b00);
    rd(2'd0, v); check("R11 double change ignored", v, 16'h0103);
    wr(2'd2, 16'h0001);           // direction up, source still quadrature
    quad(2'b01); quad(2'b11);
    rd(2'd0, v); check("R12 quad needs direction 10", v, 16'h0103);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_hold();
    t_load_count();
    t_stop_src();
    t_down();
    irq_seen = 0;
    t_ovf(1'b0, 16'hFFFE, 1'b1);
    t_ovf(1'b1, 16'h7FFE, 1'b1);
    t_ovf(1'b0, 16'h7FFE, 1'b0);
    t_match();
    t_quad();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule